// File: doc/BRIEF.md
# Per-core cache purge control register

This block holds the control registers through which a host starts and tracks a purge of one core's second-level (L2) and third-level (L3) caches. A register-bus slave accepts reads, plain writes and writes under a bit mask. Two 64-bit registers are exposed, one per cache level. Each register has a start bit and a 4-bit purge-kind field. The L2 register also carries a read-only busy flag. One small engine stub per level stands in for the real flush. It stays busy for a parameterised number of cycles and then reports completion.

The two levels use different completion handshakes. On L2, the start bit stays set after the purge ends. The host polls the busy flag and then writes the start bit back to zero itself. On L3, the start bit is itself the status: hardware clears it when the purge ends. The first-level cache is write-through, so it needs no purge and is not modelled.

Bits are named here in MSB-0 order, as the host sees them, where MSB-0 bit n is value bit 63-n. Each engine's busy state and the kind it latched are brought out as observation pins.

Top module: `purge_ctl`

## Requirements
- R1: After reset both registers read as zero and both engines are idle (`purge_busy_o` = 0, `purge_kind_o` = 0).
- R2: The L2 register is at offset 0x1080E and the L3 register at 0x1180E.
  - The start bit is MSB-0 bit 0 (value 0x8000000000000000).
  - The kind field is MSB-0 bits 1..4 (value bits 62:59). Kind 0 means a full flush or purge.
  - The L2 busy flag is MSB-0 bit 9 (value 0x0040000000000000).
  - All other bits read 0. Any other offset reads 0.
- R3: A write changes only the writable bits selected by `wmask_i`. Every other bit keeps its value. A plain write uses an all-ones mask.
- R4: A 0-to-1 transition of a start bit while that level's engine is idle launches one purge. The launch happens in the same edge as the write. The engine latches the kind value written in that same access and shows it on `purge_kind_o` (L2 in bits 3:0, L3 in bits 7:4).
- R5: A launched purge keeps the engine busy for exactly LAT_L2 (L2) or LAT_L3 (L3) cycles.
- R6: The L2 busy flag reads 1 while the L2 purge runs and 0 after it ends. The L2 start bit stays 1 after the purge ends until the host writes it to 0.
- R7: The L3 start bit reads 1 while the L3 purge runs. Hardware clears it in the same edge at which the engine goes idle.
- R8: Writes to a kind field while its engine is busy are ignored.
- R9: The busy flag and the reserved bits are read-only. Writing ones to them neither changes a read-back nor starts a purge.
- R10: A start write that is not a 0-to-1 transition on an idle engine launches nothing. This covers three cases:
  - writing 1 to an L2 start bit that is already 1;
  - setting the L2 start bit while the L2 engine is busy;
  - writing 0 to the L3 start bit during a purge, which also leaves the bit at 1.
- R11: Read data appears on `rdata_o`, with `rvalid_o` high, one cycle after the read request. It reflects the register state before the request's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Local register offset |
| wdata_i | input | 64 | Write data |
| wmask_i | input | 64 | Write bit mask, 1 = update bit |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read data |
| purge_busy_o | output | 2 | Engine busy, bit 0 = L2, bit 1 = L3 |
| purge_kind_o | output | 8 | Latched purge kind, 3:0 = L2, 7:4 = L3 |

## Verification
The bench sweeps all sixteen kind values on both levels.

- **Kind latching.** It checks the latched kind, so a design that latched the old field value instead of the value written with the start bit is caught.
- **Purge length.** Busy is sampled on the last busy cycle and on the first idle cycle, which exposes a counter that is off by one.
- **Start-bit handshakes.** A design that cleared the L2 start bit itself, or left the L3 request set after the purge, fails the read-back after completion.
- **Ignored writes.** The bench also makes:
  - kind writes while busy;
  - re-sets of a start bit that is already set;
  - clear writes to the L3 request during a purge;
  - writes to the busy flag and reserved bits.

  Each is followed by a read-back and a busy-pin check, so a design that honoured any of these writes shows a changed value or a spurious purge.
- **Masked writes.** Every mask over the kind field is compared against the merged value computed in the bench.

// File: rtl/purge_ctl_pkg.sv
package purge_ctl_pkg;
  localparam int REG_W    = 64;
  localparam int ADDR_W   = 20;
  localparam int KIND_W   = 4;
  localparam int N_LEVEL  = 2;
  // MSB-0 bit n sits at value index REG_W-1-n
  localparam int START_IX = REG_W - 1 - 0;
  localparam int KIND_HI  = REG_W - 1 - 1;
  localparam int KIND_LO  = REG_W - 1 - 4;
  localparam int BUSY_IX  = REG_W - 1 - 9;
  localparam logic [ADDR_W-1:0] L2_OFS = 20'h1080E;
  localparam logic [ADDR_W-1:0] L3_OFS = 20'h1180E;

  typedef enum logic [0:0] {LVL_L2 = 1'b0, LVL_L3 = 1'b1} level_e;

  function automatic logic [ADDR_W-1:0] level_ofs(input int lv);
    return (lv == 0) ? L2_OFS : L3_OFS;
  endfunction
endpackage

// File: rtl/purge_engine.sv
module purge_engine #(
  parameter int LATENCY = 16,
  parameter int KIND_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [KIND_W-1:0] kind_o
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LATENCY - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [KIND_W-1:0] kind_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;
  assign kind_o = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_INIT;
      kind_q <= kind_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_INIT); // R5
  AST_END_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == '0); // R5
  AST_KIND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(kind_q)); // R4
endmodule

// File: rtl/purge_reg.sv
module purge_reg
  import purge_ctl_pkg::*;
#(
  parameter bit SELF_CLEAR = 1'b0,
  parameter bit HAS_BUSY   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              start_d_i,
  input  logic              start_m_i,
  input  logic [KIND_W-1:0] kind_d_i,
  input  logic [KIND_W-1:0] kind_m_i,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  output logic              start_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [REG_W-1:0]  image_o
);
  logic              start_q;
  logic [KIND_W-1:0] kind_q;
  logic              start_wr;
  logic [KIND_W-1:0] kind_nx;

  assign start_wr = wr_i && start_m_i;
  assign kind_nx  = (wr_i && !eng_busy_i) ? ((kind_q & ~kind_m_i) | (kind_d_i & kind_m_i))
                                          : kind_q;
  assign start_o  = start_wr && start_d_i && !start_q && !eng_busy_i;
  assign kind_o   = kind_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kind_q <= '0;
    else         kind_q <= kind_nx;
  end

  generate
    if (SELF_CLEAR) begin : g_self
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         start_q <= 1'b0;
        else if (eng_done_i) start_q <= 1'b0;
        else if (start_o)    start_q <= 1'b1;
      end
      AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_done_i |=> !start_q); // R7
      AST_REQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_busy_i |-> start_q); // R7
    end else begin : g_host
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       start_q <= 1'b0;
        else if (start_wr) start_q <= start_d_i;
      end
      AST_TRIG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_done_i && start_q && !start_wr |=> start_q); // R6
    end
  endgenerate

  always_comb begin
    image_o = '0;
    image_o[START_IX] = start_q;
    image_o[KIND_HI:KIND_LO] = kind_q;
    if (HAS_BUSY) image_o[BUSY_IX] = eng_busy_i;
  end

  AST_KIND_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy_i && $past(eng_busy_i) |-> $stable(kind_q)); // R8
endmodule

// File: rtl/purge_ctl.sv
module purge_ctl
  import purge_ctl_pkg::*;
#(
  parameter int LAT_L2 = 16,
  parameter int LAT_L3 = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  wmask_i,
  output logic              rvalid_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic [N_LEVEL-1:0]        purge_busy_o,
  output logic [N_LEVEL*KIND_W-1:0] purge_kind_o
);
  logic [N_LEVEL-1:0] sel;
  logic [REG_W-1:0]   image [N_LEVEL];
  logic [REG_W-1:0]   rd_mux;
  logic               rvalid_q;
  logic [REG_W-1:0]   rdata_q;
  logic               unused_bits;

  assign unused_bits = ^{wdata_i[KIND_LO-1:0], wmask_i[KIND_LO-1:0]};

  generate
    for (genvar lv = 0; lv < N_LEVEL; lv++) begin : g_lvl
      logic              start;
      logic [KIND_W-1:0] kind_wr;
      logic              busy;
      logic              done;
      logic [KIND_W-1:0] kind_run;

      assign sel[lv] = (addr_i == level_ofs(lv));

      purge_reg #(
        .SELF_CLEAR (lv == int'(LVL_L3)),
        .HAS_BUSY   (lv == int'(LVL_L2))
      ) u_reg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (req_i && we_i && sel[lv]),
        .start_d_i  (wdata_i[START_IX]),
        .start_m_i  (wmask_i[START_IX]),
        .kind_d_i   (wdata_i[KIND_HI:KIND_LO]),
        .kind_m_i   (wmask_i[KIND_HI:KIND_LO]),
        .eng_busy_i (busy),
        .eng_done_i (done),
        .start_o    (start),
        .kind_o     (kind_wr),
        .image_o    (image[lv])
      );

      purge_engine #(
        .LATENCY (lv == 0 ? LAT_L2 : LAT_L3),
        .KIND_W  (KIND_W)
      ) u_eng (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .kind_i  (kind_wr),
        .busy_o  (busy),
        .done_o  (done),
        .kind_o  (kind_run)
      );

      assign purge_busy_o[lv] = busy;
      assign purge_kind_o[lv*KIND_W +: KIND_W] = kind_run;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int lv = 0; lv < N_LEVEL; lv++)
      if (sel[lv]) rd_mux = image[lv];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !(|sel) |=> rdata_o == '0); // R2
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i) && !$past(we_i)); // R11
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel)); // R2
endmodule

// File: tb/purge_ctl_test.sv
`timescale 1ns/1ps
module purge_ctl_test;
  localparam int L2L = 5;
  localparam int L3L = 7;
  localparam logic [19:0] A2 = 20'h1080E;
  localparam logic [19:0] A3 = 20'h1180E;
  localparam logic [63:0] TRIG = 64'h8000_0000_0000_0000;
  localparam logic [63:0] BUSY = 64'h0040_0000_0000_0000;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] KMSK = 64'hF << 59;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [19:0] addr = '0;
  logic [63:0] wdata = '0, wmask = '0;
  logic rvalid;
  logic [63:0] rdata;
  logic [1:0] pbusy;
  logic [7:0] pkind;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [63:0] rv;

  always #5 clk = ~clk;

  purge_ctl #(.LAT_L2(L2L), .LAT_L3(L3L)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .wmask_i(wmask), .rvalid_o(rvalid), .rdata_o(rdata),
    .purge_busy_o(pbusy), .purge_kind_o(pkind));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; consumes one clock edge
  task automatic wr(input logic [19:0] a, input logic [63:0] d, input logic [63:0] m);
    req = 1; we = 1; addr = a; wdata = d; wmask = m;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [63:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    chk(rvalid === 1'b1, "R11 rvalid", {63'd0, rvalid}, 64'd1);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] old;
    logic [63:0] d;
    idle(2);
    rst_n = 1;
    @(negedge clk);
    chk(pbusy == 2'b00 && pkind == 8'h00, "R1 engines idle", {56'd0, pkind}, 0);
    rd(A2, rv); chk(rv == 0, "R1 L2 reset", rv, 0);
    rd(A3, rv); chk(rv == 0, "R1 L3 reset", rv, 0);
    rd(20'h1080F, rv); chk(rv == 0, "R2 unmapped", rv, 0);

    // L2 sweep over all kinds
    for (int t = 0; t < 16; t++) begin
      logic [63:0] kf;
      kf = 64'(t) << 59;
      wr(A2, TRIG | kf, ONES);
      chk(pbusy[0] == 1'b1, "R4 L2 start", {63'd0, pbusy[0]}, 1);
      chk(pkind[3:0] == 4'(t), "R4 L2 kind latched", {60'd0, pkind[3:0]}, 64'(t));
      rd(A2, rv); chk(rv == (TRIG | kf | BUSY), "R6 L2 busy read", rv, TRIG | kf | BUSY);
      wr(A2, ~kf, KMSK);
      idle(L2L - 3);
      chk(pbusy[0] == 1'b1, "R5 L2 last busy cycle", {63'd0, pbusy[0]}, 1);
      idle(1);
      chk(pbusy[0] == 1'b0, "R5 L2 idle after latency", {63'd0, pbusy[0]}, 0);
      rd(A2, rv); chk(rv == (TRIG | kf), "R6 R8 L2 after purge", rv, TRIG | kf);
      wr(A2, TRIG, TRIG);
      chk(pbusy[0] == 1'b0, "R10 L2 re-set no start", {63'd0, pbusy[0]}, 0);
      wr(A2, 0, TRIG);
      rd(A2, rv); chk(rv == kf, "R3 L2 trig cleared kind kept", rv, kf);
    end

    // L3 sweep over all kinds
    for (int t = 0; t < 16; t++) begin
      logic [63:0] kf;
      kf = 64'(t) << 59;
      wr(A3, TRIG | kf, ONES);
      chk(pbusy[1] == 1'b1, "R4 L3 start", {63'd0, pbusy[1]}, 1);
      chk(pkind[7:4] == 4'(t), "R4 L3 kind latched", {60'd0, pkind[7:4]}, 64'(t));
      rd(A3, rv); chk(rv == (TRIG | kf), "R7 L3 req set", rv, TRIG | kf);
      wr(A3, ~kf, TRIG | KMSK);
      idle(L3L - 4);
      rd(A3, rv); chk(rv == (TRIG | kf), "R10 R8 L3 clear ignored", rv, TRIG | kf);
      chk(pbusy[1] == 1'b1, "R5 L3 last busy cycle", {63'd0, pbusy[1]}, 1);
      idle(1);
      chk(pbusy[1] == 1'b0, "R5 L3 idle after latency", {63'd0, pbusy[1]}, 0);
      rd(A3, rv); chk(rv == kf, "R7 L3 req self-cleared", rv, kf);
    end

    // read-only busy and reserved bits
    wr(A2, ONES, ~TRIG);
    chk(pbusy == 2'b00, "R9 no start from ro write", {62'd0, pbusy}, 0);
    rd(A2, rv); chk(rv == KMSK, "R9 R2 ro bits", rv, KMSK);

    // masked write sweep over kind field
    old = KMSK;
    for (int m = 0; m < 16; m++) begin
      d = 64'(m ^ 4'h5) << 59;
      wr(A3, d, 64'(m) << 59);
      old = (old & ~(64'(m) << 59)) | (d & (64'(m) << 59));
      rd(A3, rv); chk(rv == old, "R3 masked kind", rv, old);
    end

    // L2 trigger toggled while busy: only one purge
    wr(A2, TRIG, TRIG | KMSK);
    wr(A2, 0, TRIG);
    wr(A2, TRIG, TRIG);
    idle(L2L - 3);
    chk(pbusy[0] == 1'b1, "R10 L2 still first purge", {63'd0, pbusy[0]}, 1);
    idle(1);
    chk(pbusy[0] == 1'b0, "R10 L2 no second purge", {63'd0, pbusy[0]}, 0);
    rd(A2, rv); chk(rv == TRIG, "R10 L2 trig value kept", rv, TRIG);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule